// File: doc/BRIEF.md
# Oversampling Serial Receiver with Line Status

This block turns an asynchronous serial line into characters. It uses a baud tick that runs at sixteen times the bit rate. It hunts for a falling edge and confirms the start bit at mid-bit. It then samples each data bit, the optional parity bit and the first stop bit once per bit time.

The character format is taken from a six-bit line-control input, which is read live. That input sets:
- the word length, from five to eight bits;
- whether parity is used;
- even or odd parity;
- stick parity;
- one or two stop bits.

Each finished character goes into a one-entry receive buffer and raises data ready. Parity errors, framing errors, overruns and break conditions are collected as sticky flags. A read strobe on the data register clears data ready. A read strobe on the status register clears the four error flags.

A loopback select makes the receiver listen to the local transmitter's serial output instead of the external line. This lets the transmit and receive paths be tested without outside wiring.

Top module: `serial_rx_lsr`

## Requirements
- R1: `line_ctrl[1:0]` selects the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits arrive least-significant first, and the unused upper bits of `rx_data` read as 0.
- R2: `line_ctrl[3]` enables a parity bit after the data bits. `line_ctrl[4]` selects even parity (1) or odd parity (0), counting the ones in the data bits together with the parity bit. A mismatch sets `parity_err`.
- R3: When `line_ctrl[5]` (stick) and `line_ctrl[3]` are both set, the expected parity bit is the inverse of `line_ctrl[4]`, whatever the data is.
- R4: A character whose first stop bit samples as 0, and that contains at least one 1 bit, sets `framing_err`.
- R5: When the start, data, parity and stop samples are all 0, `break_int` is set and `framing_err` is not. One character of value 0 is delivered, and no further character is received until the line has returned to 1.
- R6: If a character completes while `data_ready` is still set, `overrun_err` is set and the new character replaces the old one in `rx_data`.
- R7: `data_ready` is set when a character completes. It is cleared only by `rd_data`.
- R8: `rd_status` clears `overrun_err`, `parity_err`, `framing_err` and `break_int`, and leaves `data_ready` unchanged.
- R9: A start bit is accepted only if the line is still 0 at the eighth baud tick after the falling edge. A shorter low pulse produces no character.
- R10: With `loop_en` set, the receiver takes its input from `tx_loop` and ignores `rx_serial`.
- R11: `line_ctrl[2]` (two stop bits) has no effect on reception. Only the first stop bit is checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rx_serial | input | 1 | External serial input, idle high |
| tx_loop | input | 1 | Serial output of the local transmitter |
| loop_en | input | 1 | Selects `tx_loop` as the receive source |
| line_ctrl | input | 6 | Word length [1:0], two stop [2], parity enable [3], even [4], stick [5] |
| rd_data | input | 1 | Data register read strobe |
| rd_status | input | 1 | Status register read strobe |
| rx_data | output | 8 | Receive buffer |
| data_ready | output | 1 | A character is waiting |
| overrun_err | output | 1 | A character was overwritten |
| parity_err | output | 1 | Parity mismatch seen |
| framing_err | output | 1 | First stop bit was 0 |
| break_int | output | 1 | Line held low for a whole character |

## Verification
If the bit counter or word-length decode goes wrong, `rx_data` shows bits that are shifted or not masked at the first `data_ready` edge, about one character time after the start bit. If the parity or stop-bit sampling state is wrong, the result is a false or missing `parity_err` or `framing_err` on that same character. If the framer fails to park after a break, a run of extra zero characters appears, one every character time, visible as repeated `data_ready` or `overrun_err`. Mis-ordered set and clear logic in the status register shows up within one cycle of a read strobe.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int CTRL_W = 6;
  localparam int C_WLEN_LO = 0;
  localparam int C_WLEN_HI = 1;
  localparam int C_TWO_STOP = 2;
  localparam int C_PAR_EN = 3;
  localparam int C_PAR_EVEN = 4;
  localparam int C_PAR_STICK = 5;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD
  } rx_state_t;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } frame_cfg_t;
endpackage

// File: rtl/srx_line_sel.sv
module srx_line_sel #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_serial,
  input  logic tx_loop,
  input  logic loop_en,
  output logic line_q
);
  logic              raw;
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  assign raw = loop_en ? tx_loop : rx_serial;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = raw;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], raw};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign line_q = sync_q[STAGES-1];
endmodule

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  frame_cfg_t    cfg,
  output logic          done,
  output logic [DW-1:0] done_data,
  output logic          done_perr,
  output logic          done_ferr,
  output logic          done_brk
);
  localparam int CNT_W = $clog2(OVS);
  localparam int BIT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);
  localparam logic [BIT_W-1:0] MIN_BITS = BIT_W'(DW - 3);

  rx_state_t        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [DW-1:0]    sh_q, sh_d;
  logic             par_q, par_d;
  logic             one_q, one_d;

  logic [BIT_W-1:0] nbits;
  logic [DW-1:0]    aligned;
  logic             exp_par;
  logic             at_last;
  logic             stop_sample;

  assign nbits   = MIN_BITS + BIT_W'(cfg.wlen);
  assign aligned = sh_q >> (BIT_W'(DW) - nbits);
  assign at_last = (cnt_q == LAST_CNT);

  always_comb begin
    if (cfg.par_stick)     exp_par = ~cfg.par_even;
    else if (cfg.par_even) exp_par = ^aligned;
    else                   exp_par = ~^aligned;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    par_d = par_q;
    one_d = one_q;
    if (tick) begin
      case (st_q)
        RX_IDLE: begin
          if (!line) begin
            st_d  = RX_START;
            cnt_d = '0;
          end
        end
        RX_START: begin
          if (cnt_q == MID_CNT) begin
            cnt_d = '0;
            if (line) begin
              st_d = RX_IDLE;
            end else begin
              st_d  = RX_DATA;
              bit_d = '0;
              one_d = 1'b0;
              par_d = 1'b0;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (at_last) begin
            cnt_d = '0;
            sh_d  = {line, sh_q[DW-1:1]};
            one_d = one_q | line;
            bit_d = bit_q + 1'b1;
            if (bit_q == nbits - 1'b1) st_d = cfg.par_en ? RX_PAR : RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (at_last) begin
            cnt_d = '0;
            par_d = line;
            one_d = one_q | line;
            st_d  = RX_STOP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (at_last) begin
            cnt_d = '0;
            st_d  = line ? RX_IDLE : RX_HOLD;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        RX_HOLD: begin
          if (line) st_d = RX_IDLE;
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
      one_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      par_q <= par_d;
      one_q <= one_d;
    end
  end

  assign stop_sample = tick && (st_q == RX_STOP) && at_last;
  assign done        = stop_sample;
  assign done_brk    = stop_sample && !line && !one_q;
  assign done_ferr   = stop_sample && !line && one_q;
  assign done_perr   = stop_sample && cfg.par_en && !done_brk && (par_q != exp_par);
  assign done_data   = aligned;
endmodule

// File: rtl/srx_status.sv
module srx_status #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [DW-1:0] done_data,
  input  logic          done_perr,
  input  logic          done_ferr,
  input  logic          done_brk,
  input  logic          rd_data,
  input  logic          rd_status,
  output logic [DW-1:0] buf_q,
  output logic          dr_q,
  output logic          oe_q,
  output logic          pe_q,
  output logic          fe_q,
  output logic          bi_q
);
  logic [DW-1:0] buf_d;
  logic          dr_d, oe_d, pe_d, fe_d, bi_d;
  logic          buf_en;

  assign buf_en = done;

  always_comb begin
    buf_d = buf_en ? done_data : buf_q;

    dr_d = dr_q;
    if (done)         dr_d = 1'b1;
    else if (rd_data) dr_d = 1'b0;

    oe_d = oe_q;
    if (done && dr_q && !rd_data) oe_d = 1'b1;
    else if (rd_status)           oe_d = 1'b0;

    pe_d = pe_q;
    if (done_perr)      pe_d = 1'b1;
    else if (rd_status) pe_d = 1'b0;

    fe_d = fe_q;
    if (done_ferr)      fe_d = 1'b1;
    else if (rd_status) fe_d = 1'b0;

    bi_d = bi_q;
    if (done_brk)       bi_d = 1'b1;
    else if (rd_status) bi_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      dr_q  <= 1'b0;
      oe_q  <= 1'b0;
      pe_q  <= 1'b0;
      fe_q  <= 1'b0;
      bi_q  <= 1'b0;
    end else begin
      buf_q <= buf_d;
      dr_q  <= dr_d;
      oe_q  <= oe_d;
      pe_q  <= pe_d;
      fe_q  <= fe_d;
      bi_q  <= bi_d;
    end
  end
endmodule

// File: rtl/serial_rx_lsr.sv
module serial_rx_lsr
  import srx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_serial,
  input  logic              tx_loop,
  input  logic              loop_en,
  input  logic [CTRL_W-1:0] line_ctrl,
  input  logic              rd_data,
  input  logic              rd_status,
  output logic [7:0]        rx_data,
  output logic              data_ready,
  output logic              overrun_err,
  output logic              parity_err,
  output logic              framing_err,
  output logic              break_int
);
  localparam int DW = 8;

  logic          line_s;
  frame_cfg_t    cfg;
  logic          fr_done;
  logic [DW-1:0] fr_data;
  logic          fr_perr;
  logic          fr_ferr;
  logic          fr_brk;
  logic          stop_sel_unused;

  assign cfg.wlen      = line_ctrl[C_WLEN_HI:C_WLEN_LO];
  assign cfg.par_en    = line_ctrl[C_PAR_EN];
  assign cfg.par_even  = line_ctrl[C_PAR_EVEN];
  assign cfg.par_stick = line_ctrl[C_PAR_STICK];
  assign stop_sel_unused = line_ctrl[C_TWO_STOP];

  srx_line_sel #(.STAGES(SYNC_STAGES)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_serial (rx_serial),
    .tx_loop   (tx_loop),
    .loop_en   (loop_en),
    .line_q    (line_s)
  );

  srx_framer #(.OVS(OVS), .DW(DW)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (baud_tick),
    .line      (line_s),
    .cfg       (cfg),
    .done      (fr_done),
    .done_data (fr_data),
    .done_perr (fr_perr),
    .done_ferr (fr_ferr),
    .done_brk  (fr_brk)
  );

  srx_status #(.DW(DW)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (fr_done),
    .done_data (fr_data),
    .done_perr (fr_perr),
    .done_ferr (fr_ferr),
    .done_brk  (fr_brk),
    .rd_data   (rd_data),
    .rd_status (rd_status),
    .buf_q     (rx_data),
    .dr_q      (data_ready),
    .oe_q      (overrun_err),
    .pe_q      (parity_err),
    .fe_q      (framing_err),
    .bi_q      (break_int)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] line_ctrl,
  input logic       rd_data,
  input logic       rd_status,
  input logic [7:0] rx_data,
  input logic       data_ready,
  input logic       overrun_err,
  input logic       parity_err,
  input logic       framing_err,
  input logic       break_int,
  input logic       fr_done,
  input logic       fr_brk
);
  function automatic logic [7:0] width_mask(input logic [1:0] w);
    return 8'hFF >> (2'd3 - w);
  endfunction

  // R1: nothing above the selected word length reaches the buffer
  a_r1_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done |=> ((rx_data & ~width_mask($past(line_ctrl[1:0]))) == 8'h00));

  // R5: a break delivers a zero character
  a_r5_break_zero_char: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && fr_brk) |=> (rx_data == 8'h00) && break_int);

  // R6: completion over unread data flags overrun
  a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && data_ready && !rd_data) |=> overrun_err);

  // R7: completion raises data ready
  a_r7_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done |=> data_ready);

  // R7: a data read with no completion drops data ready
  a_r7_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !fr_done) |=> !data_ready);

  // R8: a status read with no completion clears the error flags and keeps data ready
  a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !rd_data && !fr_done) |=>
      (!overrun_err && !parity_err && !framing_err && !break_int &&
       data_ready == $past(data_ready)));
endmodule

bind serial_rx_lsr srx_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_ctrl   (line_ctrl),
  .rd_data     (rd_data),
  .rd_status   (rd_status),
  .rx_data     (rx_data),
  .data_ready  (data_ready),
  .overrun_err (overrun_err),
  .parity_err  (parity_err),
  .framing_err (framing_err),
  .break_int   (break_int),
  .fr_done     (fr_done),
  .fr_brk      (fr_brk)
);

// File: tb/serial_rx_lsr_tb.sv
module serial_rx_lsr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int BIT_CLK    = 16 * TICK_DIV;
  localparam int NVEC       = 11;

  // {line_ctrl[5:0], data[7:0], flip_parity, stop_value, exp_pe, exp_fe}
  localparam logic [17:0] VEC [NVEC] = '{
    {6'b000011, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0},
    {6'b000000, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0},
    {6'b011001, 8'h2D, 1'b0, 1'b1, 1'b0, 1'b0},
    {6'b001010, 8'h5A, 1'b0, 1'b1, 1'b0, 1'b0},
    {6'b011011, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b0},
    {6'b001011, 8'h81, 1'b1, 1'b1, 1'b1, 1'b0},
    {6'b111011, 8'h77, 1'b0, 1'b1, 1'b0, 1'b0},
    {6'b101011, 8'h0F, 1'b1, 1'b1, 1'b1, 1'b0},
    {6'b000011, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b1},
    {6'b000111, 8'h5E, 1'b0, 1'b1, 1'b0, 1'b0},
    {6'b000010, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       drv = 1'b1;
  logic       use_loop = 1'b0;
  logic       loop_en = 1'b0;
  logic [5:0] line_ctrl = 6'b000011;
  logic       rd_data = 1'b0;
  logic       rd_status = 1'b0;
  logic       rx_serial;
  logic       tx_loop;
  logic [7:0] rx_data;
  logic       data_ready, overrun_err, parity_err, framing_err, break_int;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int tdiv = 0;

  assign rx_serial = use_loop ? 1'b0 : drv;
  assign tx_loop   = use_loop ? drv : 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tdiv      <= (tdiv + 1) % TICK_DIV;
    baud_tick <= rst_n && (tdiv == 0);
  end

  serial_rx_lsr u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_serial(rx_serial),
    .tx_loop(tx_loop), .loop_en(loop_en), .line_ctrl(line_ctrl),
    .rd_data(rd_data), .rd_status(rd_status), .rx_data(rx_data),
    .data_ready(data_ready), .overrun_err(overrun_err), .parity_err(parity_err),
    .framing_err(framing_err), .break_int(break_int)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int nbits);
    drv = v;
    repeat (nbits * BIT_CLK) @(negedge clk);
  endtask

  function automatic logic [7:0] masked(input logic [5:0] c, input logic [7:0] d);
    return d & (8'hFF >> (3 - c[1:0]));
  endfunction

  task automatic send(input logic [5:0] c, input logic [7:0] d, input logic flip, input logic stopv);
    logic [7:0] m;
    logic       p;
    int         nb;
    m  = masked(c, d);
    nb = 5 + c[1:0];
    if (c[5])      p = ~c[4];
    else if (c[4]) p = ^m;
    else           p = ~^m;
    p = p ^ flip;
    hold_line(1'b0, 1);
    for (int i = 0; i < nb; i++) hold_line(m[i], 1);
    if (c[3]) hold_line(p, 1);
    hold_line(stopv, 1);
    hold_line(1'b1, 2);
  endtask

  task automatic pulse_reads(input logic rd, input logic rs);
    @(negedge clk);
    rd_data   = rd;
    rd_status = rs;
    @(negedge clk);
    rd_data   = 1'b0;
    rd_status = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state (R7, R8)
    check("R7 reset data_ready", data_ready, 0);
    check("R8 reset flags", {overrun_err, parity_err, framing_err, break_int}, 0);
    check("R1 reset rx_data", rx_data, 0);
    hold_line(1'b1, 2);

    // table walk: R1 R2 R3 R4 R11
    for (int k = 0; k < NVEC; k++) begin
      logic [5:0] c;
      logic [7:0] d;
      c = VEC[k][17:12];
      d = VEC[k][11:4];
      line_ctrl = c;
      send(c, d, VEC[k][3], VEC[k][2]);
      check($sformatf("R1 vec%0d data", k), rx_data, masked(c, d));
      check($sformatf("R7 vec%0d ready", k), data_ready, 1);
      check($sformatf("R2 R3 vec%0d parity", k), parity_err, VEC[k][1]);
      check($sformatf("R4 R11 vec%0d framing", k), framing_err, VEC[k][0]);
      check($sformatf("R5 vec%0d no break", k), break_int, 0);
      pulse_reads(1'b1, 1'b1);
      check($sformatf("R8 vec%0d cleared", k),
            {data_ready, overrun_err, parity_err, framing_err, break_int}, 0);
    end

    // R6 overrun keeps the newest character
    line_ctrl = 6'b000011;
    send(line_ctrl, 8'h11, 1'b0, 1'b1);
    send(line_ctrl, 8'h22, 1'b0, 1'b1);
    check("R6 overrun flag", overrun_err, 1);
    check("R6 newest kept", rx_data, 8'h22);
    // R8 status read leaves data ready
    pulse_reads(1'b0, 1'b1);
    check("R8 overrun cleared", overrun_err, 0);
    check("R8 data_ready kept", data_ready, 1);
    pulse_reads(1'b1, 1'b0);
    check("R7 read clears ready", data_ready, 0);

    // R5 break: long low, single zero character
    hold_line(1'b0, 14);
    hold_line(1'b1, 2);
    check("R5 break flag", break_int, 1);
    check("R5 no framing on break", framing_err, 0);
    check("R5 zero char", rx_data, 8'h00);
    check("R5 one char only", overrun_err, 0);
    pulse_reads(1'b1, 1'b1);
    hold_line(1'b1, 3);
    check("R5 no repeat after break", data_ready, 0);

    // R9 short low pulse rejected
    drv = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    hold_line(1'b1, 12);
    check("R9 glitch ignored", data_ready, 0);

    // R10 loopback ignores held-low external line
    use_loop = 1'b1;
    loop_en  = 1'b1;
    hold_line(1'b1, 2);
    send(line_ctrl, 8'h6B, 1'b0, 1'b1);
    check("R10 loopback data", rx_data, 8'h6B);
    check("R10 no break from external", break_int, 0);
    check("R10 ready", data_ready, 1);

    finish_run();
  end
endmodule